// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is a cycle-accurate controller and storage array for a synchronous burst SRAM. Each word holds 18 bits, arranged as two byte lanes of 8 data bits plus one parity bit per lane. Every control input is sampled on the rising clock. Two active-low address strobes can open a burst: one for the processor and one for the cache controller. They follow different rules. A processor-strobe burst always opens with a read. A controller-strobe burst can write on its first edge.

A 2-bit counter walks the low address bits through four beats, in either linear or interleaved order. A step input either advances the burst or holds it on the current word. Writes cover one or both byte lanes. Read data comes out of a register one edge after the address was taken.

The block has no pads. Its `dq_drive` output tells the pad ring when to drive the shared data bus. A write about to be taken always forces `dq_drive` low. A two-stage sleep input freezes the block while keeping the stored contents.

Top module: `burst_sram_ctrl`

## Requirements
- R1: A strobe opens a burst only when, at that edge, `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. An effective strobe at any other chip-select combination is a deselect and performs no access.
- R2: When both strobes are low and `sel_a_n`=0, only the processor strobe is acted on. The controller strobe and the write inputs then have no effect on that edge.
- R3: When `sel_a_n`=1 the processor strobe is ignored. The burst keeps running as if no strobe were present, unless the controller strobe is low, which is then a deselect.
- R4: The first edge of a processor-strobe burst is always a read, whatever the write inputs say. Later edges of that burst may write, at the burst address.
- R5: A controller-strobe start with write inputs active writes `wdata`, sampled at that same edge, to the presented address.
- R6: Write lanes are decoded as follows. `all_wr_n`=0 selects both lanes. Otherwise `lane_wr_n`=0 selects lane i wherever `lane_pick_n[i]`=0. Lane 0 is bits 7:0 plus bit 16, and lane 1 is bits 15:8 plus bit 17. No lane selected means a read.
- R7: Read data for an address accessed at edge k is on `rdata` after edge k+1.
- R8: `dq_drive` is 1 only when all of these hold:
  - `out_en_n`=0;
  - read data is valid;
  - the current inputs would not commit a write.

  It follows `out_en_n` and the write inputs without waiting for a clock.
- R9: On an edge with no effective strobe during a burst, `step_n`=0 moves to the next beat and `step_n`=1 accesses the current word again.
- R10: The beat address keeps the upper bits of the start address. With `order_ilv`=1 its low 2 bits are start XOR count; with `order_ilv`=0 they are start plus count, modulo 4. The burst wraps after four beats.
- R11: Sleep takes effect once `sleep` is seen high at two consecutive edges, and ends once `sleep` is seen low at two consecutive edges.
  - While asleep, every other input is ignored, memory is kept and `dq_drive`=0.
  - On wake, the outputs stay off until a new read.
- R12: A deselect ends the burst. Following edges without a strobe access nothing, and `dq_drive` goes to 0 after the deselect edge.
- R13: After reset no burst is open and `dq_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| proc_stb_n | input | 1 | Processor address strobe, active low |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| sel_a_n | input | 1 | Chip select A, active low; also gates the processor strobe |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| step_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Write both lanes, active low |
| lane_wr_n | input | 1 | Enable per-lane writes, active low |
| lane_pick_n | input | LANES | Per-lane write select, active low |
| addr | input | ADDR_W | Word address |
| order_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| out_en_n | input | 1 | Output enable, active low, unclocked |
| sleep | input | 1 | Sleep request, active high |
| wdata | input | LANES*(BYTE_W+1) | Write data |
| rdata | output | LANES*(BYTE_W+1) | Registered read data |
| dq_drive | output | 1 | Data bus drive enable for the pad ring |

## Verification
Some rules are checked by the in-line assertions on every cycle:
- a write never coincides with `dq_drive`;
- a processor-strobe start never writes;
- nothing is written and nothing is driven while asleep;
- the burst count steps by one;
- a deselect drops the valid read data;
- valid read data only follows a read two sampling edges earlier.

Other behaviour can only be shown by the directed scenarios:
- the exact beat order for each start offset and mode, including the wrap;
- which lanes a byte write really changes;
- strobe priority and masking seen through later reads;
- the two-edge sleep boundaries.

// File: rtl/srb_pkg.sv
`timescale 1ns/1ps
package srb_pkg;

   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2,
      ACC_DESEL = 2'd3
   } acc_e;

   // Low two address bits of beat number cnt for a burst that began at start.
   function automatic logic [1:0] srb_beat(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input logic       ilv);
      return ilv ? (start ^ cnt) : (start + cnt);
   endfunction

endpackage

// File: rtl/srb_wr_decode.sv
`timescale 1ns/1ps
module srb_wr_decode #(
   parameter int LANES = 2
) (
   input  logic             all_wr_n,
   input  logic             lane_wr_n,
   input  logic [LANES-1:0] lane_pick_n,
   output logic [LANES-1:0] lane_req
);

   if (LANES < 1) begin : g_bad_lanes
      $error("srb_wr_decode: LANES must be at least 1");
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      // global write overrides the per-lane controls
      assign lane_req[l] = ~all_wr_n | (~lane_wr_n & ~lane_pick_n[l]);
   end

endmodule

// File: rtl/srb_burst_seq.sv
`timescale 1ns/1ps
module srb_burst_seq
   import srb_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int ORDER_MODE = 0   // 0: pin selects, 1: linear only, 2: interleaved only
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic              ilv_pin,
   input  logic [ADDR_W-1:0] base_addr,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [ADDR_W-1:0] next_addr
);

   localparam int HI_W = ADDR_W - 2;

   if (ADDR_W < 3) begin : g_bad_width
      $error("srb_burst_seq: ADDR_W must be at least 3");
   end
   if (ORDER_MODE < 0 || ORDER_MODE > 2) begin : g_bad_order
      $error("srb_burst_seq: ORDER_MODE must be 0, 1 or 2");
   end

   logic            ilv;
   logic [HI_W-1:0] hi_q;
   logic [1:0]      start_q;
   logic [1:0]      cnt_q;

   if (ORDER_MODE == 1) begin : g_lin
      assign ilv = 1'b0;
   end else if (ORDER_MODE == 2) begin : g_ilv
      assign ilv = 1'b1;
   end else begin : g_pin
      assign ilv = ilv_pin;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q    <= '0;
         start_q <= '0;
         cnt_q   <= '0;
      end else if (load) begin
         hi_q    <= base_addr[ADDR_W-1:2];
         start_q <= base_addr[1:0];
         cnt_q   <= '0;
      end else if (step) begin
         cnt_q   <= cnt_q + 2'd1;
      end
   end

   assign cur_addr  = {hi_q, srb_beat(start_q, cnt_q, ilv)};
   assign next_addr = {hi_q, srb_beat(start_q, cnt_q + 2'd1, ilv)};

   assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (cnt_q == $past(cnt_q) + 2'd1));

   assert_load_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cur_addr == $past(base_addr)));

endmodule

// File: rtl/srb_array.sv
`timescale 1ns/1ps
module srb_array #(
   parameter int ADDR_W = 10,
   parameter int BYTE_W = 8,
   parameter int LANES  = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [LANES-1:0]                we,
   input  logic [ADDR_W-1:0]               waddr,
   input  logic [LANES*(BYTE_W+1)-1:0]     wdata,
   input  logic                            re,
   input  logic [ADDR_W-1:0]               raddr,
   output logic [LANES*(BYTE_W+1)-1:0]     rdata
);

   localparam int DATA_W = LANES * BYTE_W;
   localparam int WORD_W = DATA_W + LANES;
   localparam int DEPTH  = 1 << ADDR_W;

   if (DEPTH > 4096) begin : g_too_deep
      $error("srb_array: depth above 4096 words is not supported");
   end

   logic [WORD_W-1:0] mem [DEPTH];
   logic [WORD_W-1:0] wmask;

   for (genvar l = 0; l < LANES; l++) begin : g_mask
      assign wmask[l*BYTE_W +: BYTE_W] = {BYTE_W{we[l]}};
      assign wmask[DATA_W + l]         = we[l];
   end

   always_ff @(posedge clk) begin
      if (|we) begin
         mem[waddr] <= (mem[waddr] & ~wmask) | (wdata & wmask);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (re) begin
         rdata <= mem[raddr];
      end
   end

endmodule

// File: rtl/burst_sram_ctrl.sv
`timescale 1ns/1ps
module burst_sram_ctrl
   import srb_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int BYTE_W     = 8,
   parameter int LANES      = 2,
   parameter int ORDER_MODE = 0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        proc_stb_n,
   input  logic                        ctrl_stb_n,
   input  logic                        sel_a_n,
   input  logic                        sel_b,
   input  logic                        sel_c_n,
   input  logic                        step_n,
   input  logic                        all_wr_n,
   input  logic                        lane_wr_n,
   input  logic [LANES-1:0]            lane_pick_n,
   input  logic [ADDR_W-1:0]           addr,
   input  logic                        order_ilv,
   input  logic                        out_en_n,
   input  logic                        sleep,
   input  logic [LANES*(BYTE_W+1)-1:0] wdata,
   output logic [LANES*(BYTE_W+1)-1:0] rdata,
   output logic                        dq_drive
);

   localparam int WORD_W = LANES * (BYTE_W + 1);

   if (BYTE_W < 1) begin : g_bad_byte
      $error("burst_sram_ctrl: BYTE_W must be at least 1");
   end
   if (ADDR_W < 3 || ADDR_W > 12) begin : g_bad_addr
      $error("burst_sram_ctrl: ADDR_W must lie in 3..12");
   end

   // two-stage sleep synchroniser: entry and exit each need two edges
   logic [1:0] zz_q;
   logic       awake;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) zz_q <= '0;
      else        zz_q <= {zz_q[0], sleep};
   end
   assign awake = ~zz_q[1];

   // strobe qualification
   logic sel_ok, proc_go, ctrl_go, strobe, start, desel, cont;
   logic burst_on_q;

   assign sel_ok  = ~sel_a_n & sel_b & ~sel_c_n;
   assign proc_go = awake & ~proc_stb_n & ~sel_a_n;
   assign ctrl_go = awake & ~ctrl_stb_n & (proc_stb_n | sel_a_n);
   assign strobe  = proc_go | ctrl_go;
   assign start   = strobe & sel_ok;
   assign desel   = strobe & ~sel_ok;
   assign cont    = awake & ~strobe & burst_on_q;

   // write lane decode
   logic [LANES-1:0] lane_req;
   logic             wr_req;

   srb_wr_decode #(.LANES(LANES)) u_dec (
      .all_wr_n    (all_wr_n),
      .lane_wr_n   (lane_wr_n),
      .lane_pick_n (lane_pick_n),
      .lane_req    (lane_req)
   );
   assign wr_req = |lane_req;

   // access classification for this edge
   acc_e acc;

   always_comb begin
      acc = ACC_NONE;
      if (desel) begin
         acc = ACC_DESEL;
      end else if (start) begin
         acc = (ctrl_go && wr_req) ? ACC_WRITE : ACC_READ;
      end else if (cont) begin
         acc = wr_req ? ACC_WRITE : ACC_READ;
      end
   end

   logic do_write, do_read, seq_step;
   assign do_write = (acc == ACC_WRITE);
   assign do_read  = (acc == ACC_READ);
   assign seq_step = cont & ~step_n;

   // burst address generation
   logic [ADDR_W-1:0] cur_addr, next_addr, acc_addr;

   srb_burst_seq #(.ADDR_W(ADDR_W), .ORDER_MODE(ORDER_MODE)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start),
      .step      (seq_step),
      .ilv_pin   (order_ilv),
      .base_addr (addr),
      .cur_addr  (cur_addr),
      .next_addr (next_addr)
   );

   always_comb begin
      if (start)         acc_addr = addr;
      else if (seq_step) acc_addr = next_addr;
      else               acc_addr = cur_addr;
   end

   // storage
   logic [LANES-1:0]  mem_we;
   logic              rd_pend_q;
   logic [ADDR_W-1:0] rd_addr_q;

   assign mem_we = {LANES{do_write}} & lane_req;

   srb_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LANES(LANES)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mem_we),
      .waddr (acc_addr),
      .wdata (wdata),
      .re    (rd_pend_q),
      .raddr (rd_addr_q),
      .rdata (rdata)
   );

   // burst state and output pipeline
   logic out_valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         burst_on_q  <= 1'b0;
         rd_pend_q   <= 1'b0;
         rd_addr_q   <= '0;
         out_valid_q <= 1'b0;
      end else begin
         if (!awake || desel) burst_on_q <= 1'b0;
         else if (start)      burst_on_q <= 1'b1;
         rd_pend_q   <= do_read;
         rd_addr_q   <= acc_addr;
         out_valid_q <= rd_pend_q & ~do_write & ~desel & awake;
      end
   end

   assign dq_drive = ~out_en_n & out_valid_q & ~do_write & awake;

   // checks
   assert_write_tristate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      do_write |-> !dq_drive);

   assert_proc_first_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && proc_go) |-> (mem_we == '0));

   assert_sleep_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      zz_q[1] |-> (mem_we == '0 && !dq_drive));

   assert_desel_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
      desel |=> !out_valid_q);

   assert_read_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid_q) |-> $past(do_read, 2));

   assert_no_partial_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !all_wr_n |-> (lane_req == {LANES{1'b1}}));

   if (WORD_W != LANES * (BYTE_W + 1)) begin : g_bad_word
      $error("burst_sram_ctrl: inconsistent word width");
   end

endmodule

// File: tb/test_burst_sram_ctrl.sv
`timescale 1ns/1ps
module test_burst_sram_ctrl;

   localparam int AW = 6;
   localparam int W  = 18;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          proc_stb_n, ctrl_stb_n, sel_a_n, sel_b, sel_c_n, step_n;
   logic          all_wr_n, lane_wr_n, order_ilv, out_en_n, sleep;
   logic [1:0]    lane_pick_n;
   logic [AW-1:0] addr;
   logic [W-1:0]  wdata, rdata;
   logic          dq_drive;

   logic [W-1:0]  model [64];
   int            n_chk = 0;
   int            n_err = 0;
   bit            done  = 0;

   always #2.5 clk = ~clk;

   burst_sram_ctrl #(.ADDR_W(AW)) i_burst_sram_ctrl (
      .clk(clk), .rst_n(rst_n), .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n),
      .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .step_n(step_n),
      .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_pick_n(lane_pick_n),
      .addr(addr), .order_ilv(order_ilv), .out_en_n(out_en_n), .sleep(sleep),
      .wdata(wdata), .rdata(rdata), .dq_drive(dq_drive)
   );

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic idle_in;
      proc_stb_n = 1; ctrl_stb_n = 1; sel_a_n = 0; sel_b = 1; sel_c_n = 0;
      step_n = 1; all_wr_n = 1; lane_wr_n = 1; lane_pick_n = 2'b11;
      out_en_n = 0; sleep = 0; wdata = '0; addr = '0; order_ilv = 0;
   endtask

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] lane_mask(input logic [1:0] lanes);
      return {lanes[1], lanes[0], {8{lanes[1]}}, {8{lanes[0]}}};
   endfunction

   // controller-strobe write; model follows the lane rule of R6
   task automatic wr_ctl(input int a, input logic [W-1:0] d,
                         input logic gw_n, input logic lw_n, input logic [1:0] pk_n);
      logic [1:0]   lanes;
      logic [W-1:0] m;
      lanes = !gw_n ? 2'b11 : (!lw_n ? ~pk_n : 2'b00);
      m = lane_mask(lanes);
      model[a] = (model[a] & ~m) | (d & m);
      ctrl_stb_n = 0; addr = AW'(a); wdata = d;
      all_wr_n = gw_n; lane_wr_n = lw_n; lane_pick_n = pk_n;
      tick;
      idle_in;
   endtask

   task automatic rd_ctl(input int a, input string req);
      ctrl_stb_n = 0; addr = AW'(a);
      tick;
      idle_in;
      tick;
      check(req, rdata, model[a]);
      check(req, {17'd0, dq_drive}, 18'd1);
   endtask

   task automatic t_reset;
      idle_in;
      rst_n = 0;
      repeat (3) tick;
      check("R13 drive in reset", {17'd0, dq_drive}, 18'd0);
      rst_n = 1;
      tick;
      check("R13 drive after reset", {17'd0, dq_drive}, 18'd0);
   endtask

   task automatic t_fill;
      for (int a = 0; a < 64; a++) begin
         model[a] = 'x;
         wr_ctl(a, W'((a * 18'h0A31) ^ 18'h15A5A), 0, 1, 2'b11);
      end
      rd_ctl(5, "R5 global write");
      rd_ctl(63, "R7 read latency");
   endtask

   task automatic t_bytes;
      wr_ctl(6, 18'h3FFFF, 0, 1, 2'b11);
      wr_ctl(6, 18'h00000, 1, 0, 2'b10);
      rd_ctl(6, "R6 lane0");
      check("R6 lane0 value", model[6], 18'h2FF00);
      wr_ctl(6, 18'h00000, 1, 0, 2'b01);
      rd_ctl(6, "R6 lane1");
      wr_ctl(6, 18'h12345, 1, 1, 2'b00);
      rd_ctl(6, "R6 no enable");
      wr_ctl(6, 18'h2BCDE, 0, 1, 2'b11);
      rd_ctl(6, "R6 global override");
   endtask

   task automatic t_oe;
      rd_ctl(7, "R8 read");
      out_en_n = 1; #1;
      check("R8 oe off", {17'd0, dq_drive}, 18'd0);
      out_en_n = 0; #1;
      check("R8 oe on", {17'd0, dq_drive}, 18'd1);
      all_wr_n = 0; #1;
      check("R8 write forces off", {17'd0, dq_drive}, 18'd0);
      all_wr_n = 1; #1;
      check("R8 write removed", {17'd0, dq_drive}, 18'd1);
   endtask

   task automatic t_proc_first;
      proc_stb_n = 0; addr = AW'(21); all_wr_n = 0; wdata = 18'h3AAAA;
      tick;
      proc_stb_n = 1; step_n = 0; all_wr_n = 0; wdata = 18'h15555;
      model[22] = 18'h15555;
      tick;
      idle_in;
      ctrl_stb_n = 1; sel_b = 0; proc_stb_n = 0;  // deselect to end the burst
      tick;
      idle_in;
      rd_ctl(21, "R4 first edge read only");
      rd_ctl(22, "R4 later edge writes");
   endtask

   task automatic t_priority;
      proc_stb_n = 0; ctrl_stb_n = 0; addr = AW'(9); all_wr_n = 0; wdata = 18'h11111;
      tick;
      idle_in;
      tick;
      check("R2 proc wins read", rdata, model[9]);
      check("R2 proc wins drive", {17'd0, dq_drive}, 18'd1);
      rd_ctl(9, "R2 no write");
   endtask

   task automatic t_sel_ignore;
      ctrl_stb_n = 0; addr = AW'(12);
      tick;
      idle_in;
      sel_a_n = 1; proc_stb_n = 0; step_n = 0;
      tick;
      check("R3 proc ignored beat0", rdata, model[12]);
      idle_in;
      tick;
      check("R3 burst continued", rdata, model[13]);
   endtask

   task automatic t_burst(input logic ilv, input int base);
      int s;
      s = base % 4;
      order_ilv = ilv; ctrl_stb_n = 0; addr = AW'(base);
      tick;
      ctrl_stb_n = 1; step_n = 0;
      for (int k = 0; k < 5; k++) begin
         int off;
         tick;
         off = ilv ? (s ^ (k % 4)) : ((s + k) % 4);
         check(ilv ? "R10 interleaved beat" : "R10 linear beat",
               rdata, model[(base & ~3) | off]);
      end
      step_n = 1;
      tick;
      begin
         int off5;
         off5 = ilv ? (s ^ 1) : ((s + 1) % 4);
         check("R9 after last step", rdata, model[(base & ~3) | off5]);
         tick;
         check("R9 hold repeats", rdata, model[(base & ~3) | off5]);
      end
      idle_in;
   endtask

   task automatic t_deselect;
      rd_ctl(40, "R12 setup");
      ctrl_stb_n = 0; sel_b = 0;
      tick;
      check("R12 deselect drive off", {17'd0, dq_drive}, 18'd0);
      idle_in;
      step_n = 0; all_wr_n = 0; wdata = 18'h0F0F0;
      tick;
      idle_in;
      tick;
      check("R12 stays off", {17'd0, dq_drive}, 18'd0);
      rd_ctl(41, "R12 no write after deselect");
      rd_ctl(40, "R12 start unchanged");
      ctrl_stb_n = 0; sel_c_n = 1; addr = AW'(44); all_wr_n = 0; wdata = 18'h0BEEF;
      tick;
      idle_in;
      rd_ctl(44, "R1 unselected write ignored");
      rd_ctl(45, "R3 setup");
      sel_a_n = 1; proc_stb_n = 0; ctrl_stb_n = 0;
      tick;
      check("R3 ctrl deselect", {17'd0, dq_drive}, 18'd0);
      idle_in;
   endtask

   task automatic t_sleep;
      rd_ctl(30, "R11 setup");
      sleep = 1;
      tick;
      check("R11 one edge still awake", {17'd0, dq_drive}, 18'd1);
      tick;
      check("R11 asleep after two", {17'd0, dq_drive}, 18'd0);
      ctrl_stb_n = 0; all_wr_n = 0; addr = AW'(30); wdata = 18'h12345;
      tick;
      tick;
      ctrl_stb_n = 1; all_wr_n = 1;
      check("R11 asleep ignores", {17'd0, dq_drive}, 18'd0);
      sleep = 0;
      tick;
      check("R11 exit first edge", {17'd0, dq_drive}, 18'd0);
      tick;
      check("R11 off after wake", {17'd0, dq_drive}, 18'd0);
      rd_ctl(30, "R11 contents kept");
   endtask

   initial begin
      idle_in;
      rst_n = 0;
      t_reset;
      t_fill;
      t_bytes;
      t_oe;
      t_proc_first;
      t_priority;
      t_sel_ignore;
      t_burst(0, 17);
      t_burst(1, 17);
      t_burst(1, 18);
      t_burst(0, 19);
      t_deselect;
      t_sleep;
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule